// File: doc/BRIEF.md
# Time-Shared Three-Channel Multiplier Bank

This block lets three independent signal channels share one signed multiplier. Each channel supplies one sample and one coefficient per base-rate frame. The arithmetic clock runs at three times the base rate, and a one-cycle frame strobe marks the first fast cycle of each frame. On that strobe the block captures all six operands. It feeds them to the multiplier one channel per fast cycle, in the order channel 0, 1, 2. It then sorts the products back into three parallel results.

All three results are presented together with a one-cycle valid pulse. They stay unchanged until the next frame completes. The strobe-to-valid latency is fixed at the multiplier pipeline depth plus one frame of three fast cycles. This lets a filter structure built on top schedule its next stage without handshakes.

Top module: `tdm_mult_bank`

## Requirements
- R1: A synchronous active-high reset clears all three products to zero and drives the valid output low, including frames that are in flight.
- R2: For each channel i, the reported product is the full-width signed product of that channel's sample and coefficient. Sample i sits in sampleBus bits [16i+15:16i], coefficient i sits in coefBus bits [16i+15:16i], and product i sits in productBus bits [32i+31:32i].
- R3: Operands are taken only in the cycle where the frame strobe is high. Values presented on the operand buses in the other cycles of the frame do not affect the results.
- R4: The valid output is high for exactly one cycle, MUL_STAGES + 3 clock cycles after the cycle in which the frame strobe was sampled high.
- R5: The three products change only in the cycle where valid is high, and they change together. Between valid pulses they hold their last values.
- R6: With a frame strobe every third cycle, every frame produces its own correct result set, one valid pulse per frame.
- R7: Full-scale operands give exact results: -32768 x -32768 = 1073741824 and -32768 x 32767 = -1073709056.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast arithmetic clock (three times the base rate) |
| rst | input | 1 | Synchronous reset, active high |
| frameStrobe | input | 1 | One-cycle pulse marking the channel-0 slot of a frame |
| sampleBus | input | 48 | Three signed 16-bit samples, channel 0 in the low bits |
| coefBus | input | 48 | Three signed 16-bit coefficients, channel 0 in the low bits |
| productBus | output | 96 | Three signed 32-bit products, channel 0 in the low bits |
| outValid | output | 1 | One-cycle pulse when a new set of products is presented |

## Verification
The bench builds the block with 16-bit operands and a two-stage multiplier, so the strobe-to-valid latency is five cycles. That is longer than a frame, so back-to-back frames leave two frames in flight at once. This exercises the demultiplexer's slot tracking across overlapping frames. It also exercises a reset that lands while products are still in the pipeline. The 16-bit width brings the most negative operand within reach, so the full 32-bit product range is covered exactly.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // Number of channels sharing the multiplier; fixed by the frame structure.
  localparam int TDM_LANES = 3;
  localparam int SLOT_W    = $clog2(TDM_LANES);

  // Strobes passed from the control sequencer to the datapath.
  typedef struct packed {
    logic                   capture;   // latch all operands this cycle
    logic [SLOT_W-1:0]      muxSel;    // channel feeding the multiplier
    logic [TDM_LANES-2:0]   laneLoad;  // park product of channel i
    logic                   commit;    // last product out: publish all
  } tdmCtrl_t;
endpackage

// File: rtl/tdm_pipe_mult.sv
module tdm_pipe_mult #(
  parameter int DATA_W = 16,
  parameter int STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [DATA_W-1:0]   opA,
  input  logic signed [DATA_W-1:0]   opB,
  output logic signed [2*DATA_W-1:0] product
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= opA * opB;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[k] <= '0;
      else     pipe[k] <= pipe[k-1];
    end
  end

  assign product = pipe[STAGES-1];
endmodule

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pkg::*;
#(
  parameter int MUL_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     frameStrobe,
  output tdmCtrl_t ctrl
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(TDM_LANES - 1);

  logic              slotActive;
  logic [SLOT_W-1:0] slotCnt;
  logic              tagValid [MUL_STAGES];
  logic [SLOT_W-1:0] tagSlot  [MUL_STAGES];
  logic              tailValid;
  logic [SLOT_W-1:0] tailSlot;

  // Slot sequencer: restarts at channel 0 on every strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      slotActive <= 1'b0;
      slotCnt    <= '0;
    end else if (frameStrobe) begin
      slotActive <= 1'b1;
      slotCnt    <= '0;
    end else if (slotActive) begin
      if (slotCnt == LAST_SLOT) slotActive <= 1'b0;
      else                      slotCnt    <= slotCnt + 1'b1;
    end
  end

  // Tag pipeline tracks which channel each multiplier stage carries.
  always_ff @(posedge clk) begin
    if (rst) begin
      tagValid[0] <= 1'b0;
      tagSlot[0]  <= '0;
    end else begin
      tagValid[0] <= slotActive;
      tagSlot[0]  <= slotCnt;
    end
  end

  for (genvar k = 1; k < MUL_STAGES; k++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst) begin
        tagValid[k] <= 1'b0;
        tagSlot[k]  <= '0;
      end else begin
        tagValid[k] <= tagValid[k-1];
        tagSlot[k]  <= tagSlot[k-1];
      end
    end
  end

  assign tailValid = tagValid[MUL_STAGES-1];
  assign tailSlot  = tagSlot[MUL_STAGES-1];

  always_comb begin
    ctrl         = '0;
    ctrl.capture = frameStrobe;
    ctrl.muxSel  = slotCnt;
    for (int i = 0; i < TDM_LANES - 1; i++)
      ctrl.laneLoad[i] = tailValid && (tailSlot == SLOT_W'(i));
    ctrl.commit  = tailValid && (tailSlot == LAST_SLOT);
  end
endmodule

// File: rtl/tdm_datapath.sv
module tdm_datapath
  import tdm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MUL_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  tdmCtrl_t                          ctrl,
  input  logic [TDM_LANES*DATA_W-1:0]       sampleBus,
  input  logic [TDM_LANES*DATA_W-1:0]       coefBus,
  output logic [TDM_LANES*2*DATA_W-1:0]     productBus,
  output logic                              outValid
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] holdSample [TDM_LANES];
  logic signed [DATA_W-1:0] holdCoef   [TDM_LANES];
  logic signed [DATA_W-1:0] opA, opB;
  logic signed [PROD_W-1:0] mulOut;
  logic signed [PROD_W-1:0] laneStage  [TDM_LANES-1];
  logic signed [PROD_W-1:0] outReg     [TDM_LANES];

  // Input capture: operands held for the whole frame.
  for (genvar i = 0; i < TDM_LANES; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) begin
        holdSample[i] <= '0;
        holdCoef[i]   <= '0;
      end else if (ctrl.capture) begin
        holdSample[i] <= sampleBus[i*DATA_W +: DATA_W];
        holdCoef[i]   <= coefBus[i*DATA_W +: DATA_W];
      end
    end
  end

  // Time-division multiplexer in front of the shared multiplier.
  always_comb begin
    opA = '0;
    opB = '0;
    for (int i = 0; i < TDM_LANES; i++) begin
      if (ctrl.muxSel == SLOT_W'(i)) begin
        opA = holdSample[i];
        opB = holdCoef[i];
      end
    end
  end

  tdm_pipe_mult #(
    .DATA_W (DATA_W),
    .STAGES (MUL_STAGES)
  ) u_mult (
    .clk     (clk),
    .rst     (rst),
    .opA     (opA),
    .opB     (opB),
    .product (mulOut)
  );

  // Demultiplexer: early channels wait in lane registers.
  for (genvar i = 0; i < TDM_LANES - 1; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                   laneStage[i] <= '0;
      else if (ctrl.laneLoad[i]) laneStage[i] <= mulOut;
    end
  end

  // Publish all channels together when the last product emerges.
  for (genvar i = 0; i < TDM_LANES; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) outReg[i] <= '0;
      else if (ctrl.commit) begin
        if (i == TDM_LANES - 1) outReg[i] <= mulOut;
        else                    outReg[i] <= laneStage[i];
      end
    end
    assign productBus[i*PROD_W +: PROD_W] = outReg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= ctrl.commit;
  end
endmodule

// File: rtl/tdm_mult_bank.sv
module tdm_mult_bank
  import tdm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MUL_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          frameStrobe,
  input  logic [TDM_LANES*DATA_W-1:0]   sampleBus,
  input  logic [TDM_LANES*DATA_W-1:0]   coefBus,
  output logic [TDM_LANES*2*DATA_W-1:0] productBus,
  output logic                          outValid
);
  tdmCtrl_t ctrl;

  tdm_ctrl #(
    .MUL_STAGES (MUL_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .frameStrobe (frameStrobe),
    .ctrl        (ctrl)
  );

  tdm_datapath #(
    .DATA_W     (DATA_W),
    .MUL_STAGES (MUL_STAGES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .sampleBus  (sampleBus),
    .coefBus    (coefBus),
    .productBus (productBus),
    .outValid   (outValid)
  );
endmodule

// File: rtl/tdm_mult_bank_chk.sv
module tdm_mult_bank_chk
  import tdm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MUL_STAGES = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          frameStrobe,
  input logic [TDM_LANES*2*DATA_W-1:0] productBus,
  input logic                          outValid
);
  localparam int LAT = MUL_STAGES + TDM_LANES;

  logic [LAT:0] strobeHist;
  logic         rstLast;

  always_ff @(posedge clk) begin
    if (rst) strobeHist <= '0;
    else     strobeHist <= {strobeHist[LAT-1:0], frameStrobe};
  end

  always_ff @(posedge clk) rstLast <= rst;

  // R1: one edge after reset was seen, outputs are cleared
  always @(posedge clk) begin
    if (rstLast === 1'b1)
      assert_reset_clear_R1: assert (!outValid && productBus == '0)
        else $error("reset did not clear outputs");
  end

  // R4: valid follows the strobe by a fixed latency
  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    outValid == strobeHist[LAT]);

  // R4: valid is a single-cycle pulse
  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R5: products move only alongside valid
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(productBus) |-> outValid);
endmodule

bind tdm_mult_bank tdm_mult_bank_chk #(
  .DATA_W     (DATA_W),
  .MUL_STAGES (MUL_STAGES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frameStrobe (frameStrobe),
  .productBus  (productBus),
  .outValid    (outValid)
);

// File: tb/tdm_mult_bank_tb.sv
module tdm_mult_bank_tb;
  localparam int DW  = 16;
  localparam int MS  = 2;
  localparam int NCH = 3;
  localparam int LAT = MS + NCH;
  localparam int PW  = 2 * DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameStrobe = 1'b0;
  logic [NCH*DW-1:0] sampleBus = '0;
  logic [NCH*DW-1:0] coefBus = '0;
  logic [NCH*PW-1:0] productBus;
  logic outValid;

  always #10 clk = ~clk;

  tdm_mult_bank #(.DATA_W(DW), .MUL_STAGES(MS)) u_dut (
    .clk(clk), .rst(rst), .frameStrobe(frameStrobe),
    .sampleBus(sampleBus), .coefBus(coefBus),
    .productBus(productBus), .outValid(outValid)
  );

  int edgeCnt = 0;
  always @(posedge clk) edgeCnt++;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string curReq = "R1";
  int dueQ[$];
  longint e0Q[$], e1Q[$], e2Q[$];
  longint lastExp [NCH];

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, edgeCnt);
    end
  endtask

  // Compare the DUT against the reference model once per cycle.
  task automatic observe();
    bit expValid;
    expValid = (dueQ.size() > 0) && (dueQ[0] == edgeCnt);
    if (expValid) begin
      void'(dueQ.pop_front());
      lastExp[0] = e0Q.pop_front();
      lastExp[1] = e1Q.pop_front();
      lastExp[2] = e2Q.pop_front();
    end
    chk((curReq == "R1") ? "R1" : "R4", longint'(outValid), longint'(expValid));
    for (int i = 0; i < NCH; i++)
      chk(expValid ? curReq : ((curReq == "R1") ? "R1" : "R5"),
          longint'($signed(productBus[i*PW +: PW])), lastExp[i]);
  endtask

  task automatic cycle(bit strobe, int s0, int s1, int s2, int c0, int c1, int c2);
    @(negedge clk);
    observe();
    frameStrobe = strobe;
    sampleBus = {DW'(s2), DW'(s1), DW'(s0)};
    coefBus   = {DW'(c2), DW'(c1), DW'(c0)};
    if (strobe && !rst) begin
      dueQ.push_back(edgeCnt + 1 + LAT);
      e0Q.push_back(longint'(s0) * longint'(c0));
      e1Q.push_back(longint'(s1) * longint'(c1));
      e2Q.push_back(longint'(s2) * longint'(c2));
    end
  endtask

  // Non-strobe cycles carry junk operands that must be ignored (R3).
  task automatic idle(int n);
    for (int k = 0; k < n; k++)
      cycle(1'b0, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16());
  endtask

  task automatic randFrame();
    cycle(1'b1, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16());
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) lastExp[i] = 0;
    // R1: reset state
    curReq = "R1";
    idle(4);
    rst = 1'b0;

    // R2: one frame with distinct per-channel values
    curReq = "R2";
    cycle(1'b1, 3, -5, 7, 11, 13, -17);
    // R3: junk operands in the other slots of every frame
    curReq = "R3";
    idle(LAT + 3);
    cycle(1'b1, -1234, 2222, 0, 77, -9, 30000);
    idle(LAT + 4);

    // R6: back-to-back frames, one strobe every third cycle
    curReq = "R6";
    for (int f = 0; f < 12; f++) begin
      randFrame();
      idle(2);
    end
    idle(LAT + 2);

    // R7: full-scale operands
    curReq = "R7";
    cycle(1'b1, -32768, -32768, 32767, -32768, 32767, 32767);
    idle(2);
    cycle(1'b1, 0, -1, 32767, 32767, -32768, -32768);
    idle(LAT + 2);

    // R2: irregular gaps between frames
    curReq = "R2";
    for (int f = 0; f < 6; f++) begin
      randFrame();
      idle(2 + (f % 3));
    end
    idle(LAT + 2);

    // R1: reset with frames in flight
    randFrame();
    idle(2);
    randFrame();
    idle(1);
    @(negedge clk);
    observe();
    curReq = "R1";
    rst = 1'b1;
    frameStrobe = 1'b0;
    dueQ.delete(); e0Q.delete(); e1Q.delete(); e2Q.delete();
    for (int i = 0; i < NCH; i++) lastExp[i] = 0;
    idle(3);
    idle(LAT + 2);
    rst = 1'b0;
    curReq = "R2";
    cycle(1'b1, 100, -200, 300, -4, 5, -6);
    idle(LAT + 3);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule